// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Mask Unit

This block is the status and interrupt front end of a general-purpose timer. Eleven timer sources each deliver a one-cycle event pulse: three input captures, four output compares, one channel that serves as either capture or compare, counter overflow, pulse-accumulator overflow and pulse-accumulator input edge. Each pulse sets a sticky flag. The flags sit in two 8-bit flag registers. Two 8-bit mask registers use the same bit positions as the flags. A single registered interrupt request is raised whenever a flag and its mask bit are both set.

Software reaches the four registers over a simple single-cycle register bus, one byte at a time or as a 16-bit pair. A flag cannot be cleared by one write. Software must first read the register while the flag is set, then write a zero to that bit. Any new event on the flag after that read cancels the pending clear, so no event can be lost between the read and the write.

Top module: `tef_unit`

## Requirements
- R1: After reset, both flag registers, both mask registers and `irq_o` are zero.
- R2: An event pulse on `evt_i[i]` sets its flag, and the flag is readable from the next cycle. For i in 0..7 the flag is bit i of flag register 1. For i in 8..10 it is bit i-3 of flag register 2, so bits 5..7 are used and bits 0..4 always read zero.
- R3: A bus write never sets a flag, and writing a one to a flag bit leaves that flag unchanged.
- R4: A write of zero to a flag bit clears that flag only if the bit was read as one by an earlier read of the same register. A zero written without that read has no effect.
- R5: An event on a flag after the arming read and before the clearing write cancels the clear. The flag stays set until a new read and a new zero write.
- R6: An event pulse in the same cycle as a clearing write wins, and the flag stays set.
- R7: Address decoding works as follows. `bus_addr[1]` selects flags (0) or masks (1). For 8-bit access (`bus_wide`=0), `bus_addr[0]`=0 selects register 1 and `bus_addr[0]`=1 selects register 2. The byte travels on bits 7:0 of the data buses, and bits 15:8 of `bus_rdata` read zero. For 16-bit access (`bus_wide`=1), register 1 occupies bits 15:8 and register 2 occupies bits 7:0.
- R8: Mask registers are plain read/write storage. Unused positions (register 2 bits 0..4) ignore writes and read zero.
- R9: `irq_o` is registered. It rises one clock after a flag and its mask bit are both set, and it falls one clock after the last such pair is removed.
- R10: Reading one flag register arms only that register's bits. A zero write to the other register does not clear its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 11 | One-cycle event pulses, one per timer source |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 2 | [1] flags/masks, [0] register 1/2 for byte access |
| bus_wide | input | 1 | 1 = 16-bit access to both registers |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands between the arming read and the clearing write. The other is an event that coincides exactly with the clearing write. The stimulus places a read, an event pulse and a zero write on three consecutive cycles. It also issues a zero write with the matching event pulse in the same cycle. In both cases it then reads the register back to show that the flag survived. Cross-register arming is reached with a byte read of one register followed by a 16-bit zero write. The one-cycle interrupt delay is observed by probing `irq_o` on the cycle right after a mask write and again on the cycle after that.

// File: rtl/tef_pkg.sv
// Package: shared helpers for the timer event flag unit.
// Assumes REG_W < NUM_SRC <= 2*REG_W and a 16-bit pair fits in 32 bits.
package tef_pkg;

    // Map source index to its bit in the 16-bit word (register 1 high byte).
    function automatic int word_pos(input int idx, input int reg_w, input int num_src);
        if (idx < reg_w) return reg_w + idx;
        return idx + reg_w - num_src;
    endfunction

    // Bits of the word that hold a real flag or mask bit.
    function automatic logic [31:0] valid_bits(input int reg_w, input int num_src);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < num_src; i++) v[word_pos(i, reg_w, num_src)] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/tef_bus_decode.sv
// Module: register bus decoder and read multiplexer.
// Decodes byte enables for flag/mask access and aligns write data.
// Assumes bus_rd and bus_wr are never asserted together.
module tef_bus_decode #(
    parameter int REG_W = 8,
    localparam int WORD_W = 2 * REG_W
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wide,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] flag_word,
    input  logic [WORD_W-1:0] mask_word,
    output logic [1:0]        flag_rd_be,
    output logic [1:0]        flag_wr_be,
    output logic [1:0]        mask_wr_be,
    output logic [WORD_W-1:0] wdata_al,
    output logic [WORD_W-1:0] bus_rdata
);
    logic [1:0]        byte_en;
    logic [WORD_W-1:0] sel_word;

    // Byte enables: [1] = register 1 (high byte), [0] = register 2 (low byte).
    always_comb begin
        if (bus_wide)         byte_en = 2'b11;
        else if (bus_addr[0]) byte_en = 2'b01;
        else                  byte_en = 2'b10;
    end

    // Route strobes to the flag or mask bank.
    always_comb begin
        flag_rd_be = (bus_rd && !bus_addr[1]) ? byte_en : 2'b00;
        flag_wr_be = (bus_wr && !bus_addr[1]) ? byte_en : 2'b00;
        mask_wr_be = (bus_wr &&  bus_addr[1]) ? byte_en : 2'b00;
    end

    // Align byte write data to both lanes; byte enables pick the lane.
    always_comb begin
        wdata_al = bus_wide ? bus_wdata : {bus_wdata[REG_W-1:0], bus_wdata[REG_W-1:0]};
    end

    // Read multiplexer with byte data returned on the low lane.
    always_comb begin
        sel_word  = bus_addr[1] ? mask_word : flag_word;
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_wide)         bus_rdata = sel_word;
            else if (bus_addr[0]) bus_rdata[REG_W-1:0] = sel_word[REG_W-1:0];
            else                  bus_rdata[REG_W-1:0] = sel_word[WORD_W-1:REG_W];
        end
    end
endmodule

// File: rtl/tef_flag_cell.sv
// Module: one sticky event flag with its read-then-write-zero clear guard.
// An event sets the flag and disarms any pending clear; a read of a set
// flag arms it; a zero write clears it only when armed.
// Assumes rd_i and wr_i are not asserted in the same cycle.
module tef_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic armed_q;
    logic clr_req;

    assign clr_req = wr_i && !wbit_i;

    // Flag state: event has priority over an armed clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_o <= 1'b0;
        else if (evt_i)              flag_o <= 1'b1;
        else if (clr_req && armed_q) flag_o <= 1'b0;
    end

    // Arm state: set by reading a set flag, dropped by any event or zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)               armed_q <= 1'b0;
        else if (evt_i)           armed_q <= 1'b0;
        else if (clr_req)         armed_q <= 1'b0;
        else if (rd_i && flag_o)  armed_q <= 1'b1;
    end

    // R3: a flag only ever rises after an event pulse.
    a_r3_only_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(evt_i));

    // R6: an event always leaves the flag set in the next cycle.
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_o);

    // R4: a flag falls only after a zero write to it.
    a_r4_clear_by_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(wr_i && !wbit_i));

    // R5: a flag falls only while armed by an earlier read.
    a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(armed_q));
endmodule

// File: rtl/tef_irq.sv
// Module: registered interrupt request from flags qualified by masks.
// Assumes flag and mask words share bit positions.
module tef_irq #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] flag_word,
    input  logic [WORD_W-1:0] mask_word,
    output logic              irq_o
);
    // Register the OR of enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(flag_word & mask_word);
    end

    // R9: a request needs a set flag in the previous cycle.
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(flag_word != '0));

    // R9: a request needs a set mask bit in the previous cycle.
    a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mask_word != '0));
endmodule

// File: rtl/tef_unit.sv
// Module: timer event flag and interrupt mask unit (top).
// Holds eleven sticky event flags in two byte registers, two matching mask
// registers, and drives one registered interrupt request.
// Assumes event pulses are one cycle wide and synchronous to clk.
module tef_unit #(
    parameter int REG_W   = 8,
    parameter int NUM_SRC = 11,
    localparam int WORD_W = 2 * REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic               bus_wide,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq_o
);
    import tef_pkg::*;

    localparam logic [WORD_W-1:0] VALID = WORD_W'(valid_bits(REG_W, NUM_SRC));

    logic [1:0]         flag_rd_be;
    logic [1:0]         flag_wr_be;
    logic [1:0]         mask_wr_be;
    logic [WORD_W-1:0]  wdata_al;
    logic [WORD_W-1:0]  flag_word;
    logic [WORD_W-1:0]  mask_q;
    logic [NUM_SRC-1:0] flag_src;

    tef_bus_decode #(.REG_W(REG_W)) u_dec (
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wide   (bus_wide),
        .bus_wdata  (bus_wdata),
        .flag_word  (flag_word),
        .mask_word  (mask_q),
        .flag_rd_be (flag_rd_be),
        .flag_wr_be (flag_wr_be),
        .mask_wr_be (mask_wr_be),
        .wdata_al   (wdata_al),
        .bus_rdata  (bus_rdata)
    );

    // One flag cell per source, wired to the byte lane that holds it.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        localparam int POS  = word_pos(i, REG_W, NUM_SRC);
        localparam int LANE = POS / REG_W;
        tef_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_i[i]),
            .rd_i   (flag_rd_be[LANE]),
            .wr_i   (flag_wr_be[LANE]),
            .wbit_i (wdata_al[POS]),
            .flag_o (flag_src[i])
        );
    end

    // Gather cell outputs into the word layout; unused positions stay zero.
    always_comb begin
        flag_word = '0;
        for (int i = 0; i < NUM_SRC; i++) flag_word[word_pos(i, REG_W, NUM_SRC)] = flag_src[i];
    end

    // Mask storage, one byte lane per register, unused bits held at zero.
    for (genvar b = 0; b < 2; b++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)             mask_q[b*REG_W +: REG_W] <= '0;
            else if (mask_wr_be[b]) mask_q[b*REG_W +: REG_W] <= wdata_al[b*REG_W +: REG_W] & VALID[b*REG_W +: REG_W];
        end
    end

    tef_irq #(.WORD_W(WORD_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_word (flag_word),
        .mask_word (mask_q),
        .irq_o     (irq_o)
    );

    // R8: a wide read of masks never shows unused positions.
    a_r8_mask_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1] && bus_wide) |-> ((bus_rdata & ~VALID) == '0));

    // R2: a wide read of flags never shows unused positions.
    a_r2_flag_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[1] && bus_wide) |-> ((bus_rdata & ~VALID) == '0));
endmodule

// File: tb/tef_unit_bench.sv
module tef_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_F1 = 2'b00, A_F2 = 2'b01, A_M1 = 2'b10, A_M2 = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt_i = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    logic        rd_chk = 1'b0, irq_chk = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        iexp_q[$];
    string       itag_q[$];
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tef_unit u_tef_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Monitor: pop expectations and compare mid-cycle.
    always @(negedge clk) begin
        logic [15:0] e;
        logic        ie;
        string       t;
        if (rd_chk) begin
            e = exp_q.pop_front(); t = tag_q.pop_front(); checks++;
            if (bus_rdata !== e) begin
                fails++; $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
            end
        end
        if (irq_chk) begin
            ie = iexp_q.pop_front(); t = itag_q.pop_front(); checks++;
            if (irq_o !== ie) begin
                fails++; $display("FAIL %s: irq=%b expected=%b", t, irq_o, ie);
            end
        end
    end

    // Driver: one bus/event cycle, pushing the expected read value.
    task automatic op(input logic rd, input logic wr, input logic [1:0] a, input logic wide,
                      input logic [15:0] wd, input logic [10:0] ev, input logic chk,
                      input logic [15:0] exp, input string tag);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wide = wide; bus_wdata = wd; evt_i = ev;
        if (chk) begin exp_q.push_back(exp); tag_q.push_back(tag); rd_chk = 1'b1; end
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_wr = 1'b0; evt_i = '0; rd_chk = 1'b0;
    endtask

    task automatic t_rd(input logic [1:0] a, input logic wide, input logic [15:0] exp, input string tag);
        op(1'b1, 1'b0, a, wide, 16'h0, 11'h0, 1'b1, exp, tag);
    endtask
    task automatic t_wr(input logic [1:0] a, input logic wide, input logic [15:0] wd, input logic [10:0] ev);
        op(1'b0, 1'b1, a, wide, wd, ev, 1'b0, 16'h0, "");
    endtask
    task automatic t_ev(input logic [10:0] ev);
        op(1'b0, 1'b0, 2'b00, 1'b0, 16'h0, ev, 1'b0, 16'h0, "");
    endtask
    task automatic t_irq(input logic exp, input string tag);
        iexp_q.push_back(exp); itag_q.push_back(tag); irq_chk = 1'b1;
        @(posedge clk); #1;
        irq_chk = 1'b0;
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R1 reset state
        t_rd(A_F1, 1'b1, 16'h0000, "R1 flags after reset");
        t_rd(A_M1, 1'b1, 16'h0000, "R1 masks after reset");
        t_irq(1'b0, "R1 irq after reset");
        // R4 zero write without read does nothing, then proper clear
        t_ev(11'h001);
        t_wr(A_F1, 1'b0, 16'h0000, 11'h0);
        t_rd(A_F1, 1'b0, 16'h0001, "R4 unarmed zero write ignored");
        t_wr(A_F1, 1'b0, 16'h0000, 11'h0);
        t_rd(A_F1, 1'b0, 16'h0000, "R4 armed zero write clears");
        // R3 writes never set, ones leave flags
        t_wr(A_F1, 1'b1, 16'hFFFF, 11'h0);
        t_rd(A_F1, 1'b1, 16'h0000, "R3 write ones sets nothing");
        t_ev(11'h008);
        t_rd(A_F1, 1'b0, 16'h0008, "R2 bit3 set");
        t_wr(A_F1, 1'b0, 16'h00FF, 11'h0);
        t_rd(A_F1, 1'b0, 16'h0008, "R3 write one keeps flag");
        t_wr(A_F1, 1'b0, 16'h00F7, 11'h0);
        t_rd(A_F1, 1'b0, 16'h0000, "R4 zero bit clears only it");
        // R2 / R7 mapping and access widths
        t_ev(11'h5A5);
        t_rd(A_F1, 1'b1, 16'hA5A0, "R2 R7 wide flag map");
        t_rd(A_F2, 1'b0, 16'h00A0, "R7 byte read register 2");
        t_rd(A_F1, 1'b0, 16'h00A5, "R7 byte read register 1");
        t_wr(A_F1, 1'b1, 16'h0000, 11'h0);
        t_rd(A_F1, 1'b1, 16'h0000, "R7 wide clear");
        // R10 arming is per register
        t_ev(11'h5A5);
        t_rd(A_F2, 1'b0, 16'h00A0, "R10 arm register 2");
        t_wr(A_F1, 1'b1, 16'h0000, 11'h0);
        t_rd(A_F1, 1'b1, 16'hA500, "R10 register 1 not cleared");
        t_wr(A_F1, 1'b0, 16'h0000, 11'h0);
        t_rd(A_F1, 1'b1, 16'h0000, "R10 register 1 cleared after own read");
        // R5 event between read and write
        t_ev(11'h002);
        t_rd(A_F1, 1'b0, 16'h0002, "R5 first read");
        t_ev(11'h002);
        t_wr(A_F1, 1'b0, 16'h0000, 11'h0);
        t_rd(A_F1, 1'b0, 16'h0002, "R5 flag survives mid-sequence event");
        t_wr(A_F1, 1'b0, 16'h0000, 11'h0);
        t_rd(A_F1, 1'b0, 16'h0000, "R5 cleared after new read");
        // R6 event coincides with clearing write
        t_ev(11'h010);
        t_rd(A_F1, 1'b0, 16'h0010, "R6 arm");
        t_wr(A_F1, 1'b0, 16'h0000, 11'h010);
        t_rd(A_F1, 1'b0, 16'h0010, "R6 event wins over clear");
        t_wr(A_F1, 1'b0, 16'h0000, 11'h0);
        t_rd(A_F1, 1'b0, 16'h0000, "R6 later clear works");
        // R8 mask storage
        t_wr(A_M1, 1'b1, 16'hFFFF, 11'h0);
        t_rd(A_M1, 1'b1, 16'hFFE0, "R8 unused mask bits read zero");
        t_wr(A_M2, 1'b0, 16'h00A5, 11'h0);
        t_rd(A_M2, 1'b0, 16'h00A0, "R8 byte mask write");
        t_rd(A_M1, 1'b1, 16'hFFA0, "R8 R7 other mask byte kept");
        t_rd(A_F1, 1'b1, 16'h0000, "R8 mask writes leave flags");
        // R9 registered interrupt
        t_wr(A_M1, 1'b1, 16'h0000, 11'h0);
        t_ev(11'h200);
        t_irq(1'b0, "R9 masked flag no irq");
        t_wr(A_M2, 1'b0, 16'h0040, 11'h0);
        t_irq(1'b0, "R9 one cycle delay on rise");
        t_irq(1'b1, "R9 irq asserted");
        t_rd(A_F2, 1'b0, 16'h0040, "R9 R2 flag register 2 bit6");
        t_wr(A_F2, 1'b0, 16'h0000, 11'h0);
        t_irq(1'b1, "R9 one cycle delay on fall");
        t_irq(1'b0, "R9 irq released");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule